// File: doc/BRIEF.md
# Burst-4 Double-Rate SRAM Access Pipeline

This block sits behind the pins of a synchronous SRAM whose single data bus carries two beats per clock, one on each clock edge. Every access moves exactly four beats. The rising edge samples a command. `cmd_hold` high means no command. Otherwise `cmd_rd` selects a read (1) or a write (0), and `cmd_addr` gives the base word. The block expands the base into four linearly incrementing word addresses and sequences the array access. Each clock half is modelled as a lane: the "rise" lane holds the even beat of a cycle and the "fall" lane holds the odd beat.

For a write, the block captures the data and per-byte enables one and two cycles after the command. It forwards them to the array's write port one cycle after each capture. For a read, it issues the two address pairs to the array's read port in the two cycles after the command. It returns the four beats after one or two cycles of latency, as chosen by `lat_two`. A valid flag, split into the same two lanes, leads the first beat by half a cycle and drops half a cycle before the last beat. The array and the write-coherency buffer are separate blocks.

The command side has no back-pressure. `cmd_ready` is a plain status pin. It is low for the one cycle after any accepted command, and a command offered in that cycle is dropped. The read return path is valid-only because the array read has fixed timing. The consumer must take every beat that `rvld_rise` marks.

Top module: `ddr_b4_sram_engine`

## Requirements
- R1: While `rst_n` is low: `cmd_ready`=1, `mem_we`=0, `mem_re`=0, `rvld_rise`=0, `rvld_fall`=0, and `rdat_rise`=`rdat_fall`=0.
- R2: When `cmd_hold` is 1 at a rising edge, no access starts. No array read or write and no valid flag result from that edge, and `cmd_ready` stays 1.
- R3: After a command is accepted at edge P, `cmd_ready` is 0 during cycle P and returns to 1 in the following cycle unless another command is accepted. A command presented while `cmd_ready` is 0 is dropped with no effect on any output.
- R4: The burst addresses for base B are B, B+1, B+2 and B+3, taken modulo 2^AW. The even offset goes on the rise lane and the odd offset on the fall lane. The pair B/B+1 comes one cycle before the pair B+2/B+3.
- R5: For a write accepted at edge P, beats 0/1 are sampled from `wdat_rise`/`wdat_fall` at edge P+1 and beats 2/3 at edge P+2. `mem_we` is 1 with the matching pair during cycles P+1 and P+2 only. Write data offered at other times is never forwarded.
- R6: The byte enables are active high. Bit i of `wben_rise`/`wben_fall` governs bits [8i+7:8i] of the same lane and beat. They reach `mem_wben_rise`/`mem_wben_fall` unchanged, together with their data.
- R7: For a read accepted at edge P, `mem_re` is 1 during cycles P and P+1, with the addresses given by R4, and is 0 otherwise.
- R8: With `lat_two`=1, the array words of pair 0 appear on `rdat_rise`/`rdat_fall` in cycle P+2 and those of pair 1 in cycle P+3. With `lat_two`=0 they appear in cycles P+1 and P+2. Outside these cycles both lanes read 0.
- R9: `rvld_rise` is 1 exactly in the two data cycles of R8. `rvld_fall` is 1 in the cycle before the first data cycle and in the first data cycle. The flag therefore rises half a cycle before beat 0 and falls half a cycle before beat 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples commands |
| rst_n | input | 1 | Asynchronous active-low reset |
| lat_two | input | 1 | Read latency select: 1 = two cycles, 0 = one cycle; changed only while idle |
| cmd_hold | input | 1 | 1 = no command this edge |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | AW | Burst base word address |
| cmd_ready | output | 1 | 0 in the cycle after an accepted command |
| wdat_rise | input | NBYTES*BYTE_W | Write data, even beat |
| wdat_fall | input | NBYTES*BYTE_W | Write data, odd beat |
| wben_rise | input | NBYTES | Byte enables, even beat |
| wben_fall | input | NBYTES | Byte enables, odd beat |
| mem_we | output | 1 | Array write strobe for one beat pair |
| mem_waddr_rise | output | AW | Array write address, even beat |
| mem_waddr_fall | output | AW | Array write address, odd beat |
| mem_wdat_rise | output | NBYTES*BYTE_W | Array write data, even beat |
| mem_wdat_fall | output | NBYTES*BYTE_W | Array write data, odd beat |
| mem_wben_rise | output | NBYTES | Array byte enables, even beat |
| mem_wben_fall | output | NBYTES | Array byte enables, odd beat |
| mem_re | output | 1 | Array read strobe for one beat pair |
| mem_raddr_rise | output | AW | Array read address, even beat |
| mem_raddr_fall | output | AW | Array read address, odd beat |
| mem_rdat_rise | input | NBYTES*BYTE_W | Array read data for `mem_raddr_rise`, same cycle |
| mem_rdat_fall | input | NBYTES*BYTE_W | Array read data for `mem_raddr_fall`, same cycle |
| rdat_rise | output | NBYTES*BYTE_W | Read data, even beat |
| rdat_fall | output | NBYTES*BYTE_W | Read data, odd beat |
| rvld_rise | output | 1 | Valid flag during the rising half |
| rvld_fall | output | 1 | Valid flag during the falling half |

## Verification
Isolated reads and writes with idle gaps show the bare latency and the flag shape under both `lat_two` settings. Reads and writes issued on every other cycle show whether successive bursts abut without gaps or overlap. A command offered one cycle after another shows whether the two-cycle occupancy is enforced. Bases at the top of the address space show whether the increment wraps modulo 2^AW.

Long runs mix random commands, addresses, data and partial byte enables. Junk data is offered on the write lanes whenever no write is due. Every cycle is compared against a bench model of the schedule, which separates late or early beats, swapped lanes, stray array strobes and masks that lose their alignment with their data.

// File: rtl/ddr_b4_pkg.sv
package ddr_b4_pkg;
  // two beats per clock: rise lane and fall lane
  localparam int BEATS_PER_CYCLE = 2;

  typedef enum logic {
    CMD_WRITE = 1'b0,
    CMD_READ  = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/ddr_b4_cmd_ctrl.sv
module ddr_b4_cmd_ctrl
  import ddr_b4_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hold,
  input  logic          cmd_rd,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic [AW-1:0] base,
  output logic [3:0]    rd_pipe,
  output logic [1:0]    wr_pipe
);
  cmd_kind_e kind;
  logic      accept;

  assign kind      = cmd_kind_e'(cmd_rd);
  // a burst holds the array for two cycles, so its first phase blocks a new command
  assign cmd_ready = ~(rd_pipe[0] | wr_pipe[0]);
  assign accept    = ~cmd_hold & cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      rd_pipe <= '0;
      wr_pipe <= '0;
    end else begin
      rd_pipe <= {rd_pipe[2:0], accept && (kind == CMD_READ)};
      wr_pipe <= {wr_pipe[0], accept && (kind == CMD_WRITE)};
      if (accept) base <= cmd_addr;
    end
  end

  AST_ACCEPT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_hold && cmd_ready) |=> !cmd_ready); // R3
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pipe[1:0], wr_pipe})); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hold && cmd_ready) |=> (rd_pipe[0] == 1'b0 && wr_pipe[0] == 1'b0)); // R2
endmodule

// File: rtl/ddr_b4_burst_addr.sv
module ddr_b4_burst_addr
  import ddr_b4_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                                 hi_pair,
  input  logic [AW-1:0]                        base,
  output logic [BEATS_PER_CYCLE-1:0][AW-1:0]   lane_addr
);
  localparam logic [AW-1:0] PAIR_STEP = AW'(BEATS_PER_CYCLE);

  logic [AW-1:0] pair_base;
  assign pair_base = base + (hi_pair ? PAIR_STEP : '0);

  for (genvar l = 0; l < BEATS_PER_CYCLE; l++) begin : g_lane
    localparam logic [AW-1:0] LANE_OFS = AW'(l);
    assign lane_addr[l] = pair_base + LANE_OFS;
  end
endmodule

// File: rtl/ddr_b4_wr_capture.sv
module ddr_b4_wr_capture
  import ddr_b4_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         wr_pipe,
  input  logic [BEATS_PER_CYCLE-1:0][AW-1:0] lane_addr,
  input  logic [DW-1:0]                      wdat_rise,
  input  logic [DW-1:0]                      wdat_fall,
  input  logic [NB-1:0]                      wben_rise,
  input  logic [NB-1:0]                      wben_fall,
  output logic                               mem_we,
  output logic [AW-1:0]                      mem_waddr_rise,
  output logic [AW-1:0]                      mem_waddr_fall,
  output logic [DW-1:0]                      mem_wdat_rise,
  output logic [DW-1:0]                      mem_wdat_fall,
  output logic [NB-1:0]                      mem_wben_rise,
  output logic [NB-1:0]                      mem_wben_fall
);
  logic take;
  assign take = |wr_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we         <= 1'b0;
      mem_waddr_rise <= '0;
      mem_waddr_fall <= '0;
      mem_wdat_rise  <= '0;
      mem_wdat_fall  <= '0;
      mem_wben_rise  <= '0;
      mem_wben_fall  <= '0;
    end else begin
      mem_we <= take;
      if (take) begin
        mem_waddr_rise <= lane_addr[0];
        mem_waddr_fall <= lane_addr[1];
        mem_wdat_rise  <= wdat_rise;
        mem_wdat_fall  <= wdat_fall;
        mem_wben_rise  <= wben_rise;
        mem_wben_fall  <= wben_fall;
      end
    end
  end

  AST_WR_PAIR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pipe[1] |=> (mem_we && mem_waddr_rise == $past(mem_waddr_rise) + AW'(2))); // R4
  AST_WR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pipe[0] |=> (mem_we && wr_pipe[1])); // R5
endmodule

// File: rtl/ddr_b4_rd_launch.sv
module ddr_b4_rd_launch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_two,
  input  logic [3:0]    rd_pipe,
  input  logic [DW-1:0] mem_rdat_rise,
  input  logic [DW-1:0] mem_rdat_fall,
  output logic [DW-1:0] rdat_rise,
  output logic [DW-1:0] rdat_fall,
  output logic          rvld_rise,
  output logic          rvld_fall
);
  logic [DW-1:0] st1_rise, st1_fall, st2_rise, st2_fall;
  logic          fetch;

  assign fetch = rd_pipe[0] | rd_pipe[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_rise <= '0;
      st1_fall <= '0;
      st2_rise <= '0;
      st2_fall <= '0;
    end else begin
      if (fetch) begin
        st1_rise <= mem_rdat_rise;
        st1_fall <= mem_rdat_fall;
      end
      st2_rise <= st1_rise;
      st2_fall <= st1_fall;
    end
  end

  // data cycles are the two after the address cycles, shifted by one for the long latency
  assign rvld_rise = lat_two ? (rd_pipe[2] | rd_pipe[3]) : (rd_pipe[1] | rd_pipe[2]);
  assign rvld_fall = lat_two ? (rd_pipe[1] | rd_pipe[2]) : (rd_pipe[0] | rd_pipe[1]);
  assign rdat_rise = rvld_rise ? (lat_two ? st2_rise : st1_rise) : '0;
  assign rdat_fall = rvld_rise ? (lat_two ? st2_fall : st1_fall) : '0;

  AST_VLD_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvld_rise && !$past(rvld_rise)) |-> $past(rvld_fall)); // R9
  AST_VLD_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvld_fall) |-> rvld_rise); // R9
  AST_READ_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pipe[0] |=> rd_pipe[1]); // R7
endmodule

// File: rtl/ddr_b4_sram_engine.sv
module ddr_b4_sram_engine
  import ddr_b4_pkg::*;
#(
  parameter int AW     = 12,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lat_two,
  input  logic                     cmd_hold,
  input  logic                     cmd_rd,
  input  logic [AW-1:0]            cmd_addr,
  output logic                     cmd_ready,
  input  logic [NBYTES*BYTE_W-1:0] wdat_rise,
  input  logic [NBYTES*BYTE_W-1:0] wdat_fall,
  input  logic [NBYTES-1:0]        wben_rise,
  input  logic [NBYTES-1:0]        wben_fall,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_waddr_rise,
  output logic [AW-1:0]            mem_waddr_fall,
  output logic [NBYTES*BYTE_W-1:0] mem_wdat_rise,
  output logic [NBYTES*BYTE_W-1:0] mem_wdat_fall,
  output logic [NBYTES-1:0]        mem_wben_rise,
  output logic [NBYTES-1:0]        mem_wben_fall,
  output logic                     mem_re,
  output logic [AW-1:0]            mem_raddr_rise,
  output logic [AW-1:0]            mem_raddr_fall,
  input  logic [NBYTES*BYTE_W-1:0] mem_rdat_rise,
  input  logic [NBYTES*BYTE_W-1:0] mem_rdat_fall,
  output logic [NBYTES*BYTE_W-1:0] rdat_rise,
  output logic [NBYTES*BYTE_W-1:0] rdat_fall,
  output logic                     rvld_rise,
  output logic                     rvld_fall
);
  localparam int DW = NBYTES * BYTE_W;

  logic [AW-1:0]                        base;
  logic [3:0]                           rd_pipe;
  logic [1:0]                           wr_pipe;
  logic [BEATS_PER_CYCLE-1:0][AW-1:0]   rd_lane, wr_lane;

  ddr_b4_cmd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_hold(cmd_hold), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .base(base),
    .rd_pipe(rd_pipe), .wr_pipe(wr_pipe)
  );

  ddr_b4_burst_addr #(.AW(AW)) u_rd_addr (
    .hi_pair(rd_pipe[1]), .base(base), .lane_addr(rd_lane)
  );

  ddr_b4_burst_addr #(.AW(AW)) u_wr_addr (
    .hi_pair(wr_pipe[1]), .base(base), .lane_addr(wr_lane)
  );

  assign mem_re         = rd_pipe[0] | rd_pipe[1];
  assign mem_raddr_rise = rd_lane[0];
  assign mem_raddr_fall = rd_lane[1];

  ddr_b4_wr_capture #(.AW(AW), .DW(DW), .NB(NBYTES)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_pipe(wr_pipe), .lane_addr(wr_lane),
    .wdat_rise(wdat_rise), .wdat_fall(wdat_fall),
    .wben_rise(wben_rise), .wben_fall(wben_fall),
    .mem_we(mem_we), .mem_waddr_rise(mem_waddr_rise), .mem_waddr_fall(mem_waddr_fall),
    .mem_wdat_rise(mem_wdat_rise), .mem_wdat_fall(mem_wdat_fall),
    .mem_wben_rise(mem_wben_rise), .mem_wben_fall(mem_wben_fall)
  );

  ddr_b4_rd_launch #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .lat_two(lat_two), .rd_pipe(rd_pipe),
    .mem_rdat_rise(mem_rdat_rise), .mem_rdat_fall(mem_rdat_fall),
    .rdat_rise(rdat_rise), .rdat_fall(rdat_fall),
    .rvld_rise(rvld_rise), .rvld_fall(rvld_fall)
  );

  AST_RD_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pipe[1] |-> (mem_raddr_rise == base + AW'(2) && mem_raddr_fall == base + AW'(3))); // R4
endmodule

// File: tb/ddr_b4_sram_engine_tb_top.sv
module ddr_b4_sram_engine_tb_top;
  localparam int AW = 12;
  localparam int NB = 2;
  localparam int BW = 8;
  localparam int DW = NB * BW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, lat_two, cmd_hold, cmd_rd, cmd_ready;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wdat_rise, wdat_fall;
  logic [NB-1:0] wben_rise, wben_fall;
  logic mem_we, mem_re, rvld_rise, rvld_fall;
  logic [AW-1:0] mem_waddr_rise, mem_waddr_fall, mem_raddr_rise, mem_raddr_fall;
  logic [DW-1:0] mem_wdat_rise, mem_wdat_fall, mem_rdat_rise, mem_rdat_fall;
  logic [NB-1:0] mem_wben_rise, mem_wben_fall;
  logic [DW-1:0] rdat_rise, rdat_fall;

  function automatic logic [DW-1:0] rdf(logic [AW-1:0] a);
    logic [DW-1:0] t;
    t = DW'(a);
    return (t * 16'd40503) ^ 16'hA5C3;
  endfunction

  assign mem_rdat_rise = rdf(mem_raddr_rise);
  assign mem_rdat_fall = rdf(mem_raddr_fall);

  ddr_b4_sram_engine #(.AW(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lat_two(lat_two), .cmd_hold(cmd_hold), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .wdat_rise(wdat_rise), .wdat_fall(wdat_fall),
    .wben_rise(wben_rise), .wben_fall(wben_fall), .mem_we(mem_we),
    .mem_waddr_rise(mem_waddr_rise), .mem_waddr_fall(mem_waddr_fall),
    .mem_wdat_rise(mem_wdat_rise), .mem_wdat_fall(mem_wdat_fall),
    .mem_wben_rise(mem_wben_rise), .mem_wben_fall(mem_wben_fall), .mem_re(mem_re),
    .mem_raddr_rise(mem_raddr_rise), .mem_raddr_fall(mem_raddr_fall),
    .mem_rdat_rise(mem_rdat_rise), .mem_rdat_fall(mem_rdat_fall),
    .rdat_rise(rdat_rise), .rdat_fall(rdat_fall), .rvld_rise(rvld_rise), .rvld_fall(rvld_fall)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit acc_last = 1'b0;
  bit lat_mode = 1'b1;

  // expectation ring indexed by cycle number
  bit            e_re[8], e_we[8], e_vr[8], e_vf[8], d_v[8];
  logic [AW-1:0] e_ra[8], e_wa[8];
  logic [DW-1:0] e_wdr[8], e_wdf[8], e_qr[8], e_qf[8], d_dr[8], d_df[8];
  logic [NB-1:0] e_ber[8], e_bef[8], d_br[8], d_bf[8];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick(bit req, bit rd, logic [AW-1:0] a);
    int s, p, d0, l;
    logic [AW-1:0] nx, a1, a2, a3;
    logic [DW-1:0] r0, r1, r2, r3;
    logic [NB-1:0] b0, b1, b2, b3;
    @(negedge clk);
    s = cyc % 8;
    chk(cmd_ready == !acc_last, "R3", "cmd_ready", 32'(cmd_ready), 32'(!acc_last));
    chk(mem_re == e_re[s], "R7", "mem_re", 32'(mem_re), 32'(e_re[s]));
    if (e_re[s]) begin
      nx = e_ra[s] + 1'b1;
      chk(mem_raddr_rise == e_ra[s], "R4", "raddr_rise", 32'(mem_raddr_rise), 32'(e_ra[s]));
      chk(mem_raddr_fall == nx, "R4", "raddr_fall", 32'(mem_raddr_fall), 32'(nx));
    end
    chk(mem_we == e_we[s], "R5", "mem_we", 32'(mem_we), 32'(e_we[s]));
    if (e_we[s]) begin
      nx = e_wa[s] + 1'b1;
      chk(mem_waddr_rise == e_wa[s], "R4", "waddr_rise", 32'(mem_waddr_rise), 32'(e_wa[s]));
      chk(mem_waddr_fall == nx, "R4", "waddr_fall", 32'(mem_waddr_fall), 32'(nx));
      chk(mem_wdat_rise == e_wdr[s], "R5", "wdat_rise", 32'(mem_wdat_rise), 32'(e_wdr[s]));
      chk(mem_wdat_fall == e_wdf[s], "R5", "wdat_fall", 32'(mem_wdat_fall), 32'(e_wdf[s]));
      chk(mem_wben_rise == e_ber[s], "R6", "wben_rise", 32'(mem_wben_rise), 32'(e_ber[s]));
      chk(mem_wben_fall == e_bef[s], "R6", "wben_fall", 32'(mem_wben_fall), 32'(e_bef[s]));
    end
    chk(rvld_rise == e_vr[s], "R9", "rvld_rise", 32'(rvld_rise), 32'(e_vr[s]));
    chk(rvld_fall == e_vf[s], "R9", "rvld_fall", 32'(rvld_fall), 32'(e_vf[s]));
    r0 = e_vr[s] ? e_qr[s] : '0;
    r1 = e_vr[s] ? e_qf[s] : '0;
    chk(rdat_rise == r0, "R8", "rdat_rise", 32'(rdat_rise), 32'(r0));
    chk(rdat_fall == r1, "R8", "rdat_fall", 32'(rdat_fall), 32'(r1));
    e_re[s] = 0; e_we[s] = 0; e_vr[s] = 0; e_vf[s] = 0;

    cmd_hold = !req;
    cmd_rd   = rd;
    cmd_addr = a;
    if (d_v[s]) begin
      wdat_rise = d_dr[s]; wdat_fall = d_df[s];
      wben_rise = d_br[s]; wben_fall = d_bf[s];
    end else begin
      // junk that must never reach the array (R5)
      wdat_rise = DW'($urandom); wdat_fall = DW'($urandom);
      wben_rise = NB'($urandom); wben_fall = NB'($urandom);
    end
    d_v[s] = 0;

    p = cyc + 1;
    if (req && !acc_last) begin
      acc_last = 1'b1;
      a1 = a + 1'b1; a2 = a + 2'd2; a3 = a + 2'd3;
      if (rd) begin
        e_re[p % 8] = 1; e_ra[p % 8] = a;
        e_re[(p + 1) % 8] = 1; e_ra[(p + 1) % 8] = a2;
        l  = lat_mode ? 2 : 1;
        d0 = p + l;
        e_vf[(d0 - 1) % 8] = 1; e_vf[d0 % 8] = 1;
        e_vr[d0 % 8] = 1; e_qr[d0 % 8] = rdf(a); e_qf[d0 % 8] = rdf(a1);
        e_vr[(d0 + 1) % 8] = 1; e_qr[(d0 + 1) % 8] = rdf(a2); e_qf[(d0 + 1) % 8] = rdf(a3);
      end else begin
        r0 = DW'($urandom); r1 = DW'($urandom); r2 = DW'($urandom); r3 = DW'($urandom);
        b0 = NB'($urandom); b1 = NB'($urandom); b2 = NB'($urandom); b3 = NB'($urandom);
        d_v[p % 8] = 1; d_dr[p % 8] = r0; d_df[p % 8] = r1; d_br[p % 8] = b0; d_bf[p % 8] = b1;
        d_v[(p + 1) % 8] = 1; d_dr[(p + 1) % 8] = r2; d_df[(p + 1) % 8] = r3;
        d_br[(p + 1) % 8] = b2; d_bf[(p + 1) % 8] = b3;
        e_we[(p + 1) % 8] = 1; e_wa[(p + 1) % 8] = a;
        e_wdr[(p + 1) % 8] = r0; e_wdf[(p + 1) % 8] = r1; e_ber[(p + 1) % 8] = b0; e_bef[(p + 1) % 8] = b1;
        e_we[(p + 2) % 8] = 1; e_wa[(p + 2) % 8] = a2;
        e_wdr[(p + 2) % 8] = r2; e_wdf[(p + 2) % 8] = r3; e_ber[(p + 2) % 8] = b2; e_bef[(p + 2) % 8] = b3;
      end
    end else begin
      acc_last = 1'b0;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, AW'($urandom));
  endtask

  task automatic directed();
    tick(1, 1, 12'h100); idle(5);                 // R8 R9 isolated read
    tick(1, 0, 12'h204); idle(5);                 // R5 R6 isolated write
    tick(1, 1, 12'h300); tick(1, 0, 12'h444);     // R3 second command dropped
    idle(5);
    tick(1, 0, 12'h310); tick(1, 1, 12'h555);     // R3 dropped read after write
    idle(5);
    tick(1, 1, 12'hFFE); idle(5);                 // R4 wrap on read
    tick(1, 0, 12'hFFF); idle(5);                 // R4 wrap on write
    tick(1, 1, 12'h020); tick(0, 0, 12'h0);       // alternate-cycle streaming reads
    tick(1, 1, 12'h024); tick(0, 0, 12'h0);
    tick(1, 0, 12'h028); tick(0, 0, 12'h0);
    tick(1, 1, 12'h02C); idle(6);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; lat_two = 1'b1; cmd_hold = 1'b1; cmd_rd = 1'b0; cmd_addr = '0;
    wdat_rise = '0; wdat_fall = '0; wben_rise = '0; wben_fall = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", 32'(cmd_ready), 32'd1);
    chk(mem_we == 1'b0 && mem_re == 1'b0, "R1", "mem strobes", 32'({mem_we, mem_re}), 32'd0);
    chk(rvld_rise == 1'b0 && rvld_fall == 1'b0, "R1", "valid lanes", 32'({rvld_rise, rvld_fall}), 32'd0);
    chk(rdat_rise == '0 && rdat_fall == '0, "R1", "read data", 32'(rdat_rise), 32'd0);
    rst_n = 1'b1;
    idle(4);                                      // R2 no-command edges
    lat_mode = 1'b1; lat_two = 1'b1;
    directed();
    for (int i = 0; i < 1500; i++)
      tick($urandom % 3 != 0, 1'($urandom), AW'($urandom));
    idle(6);
    lat_mode = 1'b0; lat_two = 1'b0;              // R8 short latency
    idle(2);
    directed();
    for (int i = 0; i < 1500; i++)
      tick($urandom % 3 != 0, 1'($urandom), AW'($urandom));
    idle(6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule